// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a single multi-register transfer request into a series of word transfers, one per clock cycle. A request carries a base address, a 16-bit mask of the registers to move, an up/down direction bit, a before/after step bit and a write-back bit. It is qualified by a one-cycle start pulse. For each selected register the block presents a word address and the register index. Registers are always visited from the lowest index to the highest, at rising addresses, in all four stepping modes.

When the final transfer has been issued, the block raises a completion pulse. If write-back was requested, it also presents the adjusted base address in that same cycle. A request with an empty mask is refused: the block raises an error pulse and issues no transfers. While a sequence is in progress, any further start pulse is ignored.

Top module: `bxs_seq`

## Requirements
- R1: Mask bit i selects register i. Exactly the selected registers are transferred, one per cycle on consecutive cycles, in ascending index order. The index appears on `xfer_reg_o`.
- R2: Each transfer address is 4 greater than the previous one, modulo 2^32.
- R3: Up with step-after (`up_i`=1, `pre_i`=0): the first address equals the base.
- R4: Up with step-before (`up_i`=1, `pre_i`=1): the first address equals base + 4.
- R5: Down with step-after (`up_i`=0, `pre_i`=0): the first address equals base − 4·n + 4, where n is the number of set mask bits.
- R6: Down with step-before (`up_i`=0, `pre_i`=1): the first address equals base − 4·n.
- R7: When `wb_i` was set, `wb_valid_o` pulses in the completion cycle with `wb_base_o` equal to base + 4·n (up) or base − 4·n (down). When `wb_i` was clear, `wb_valid_o` stays low.
- R8: `xfer_last_o` is high only on the final transfer. `done_o` pulses for one cycle in the cycle after the final transfer, and no transfer is shown in that cycle.
- R9: A start with an all-zero mask raises `err_o` for exactly one cycle, in the cycle after the start. It produces no transfer and no completion pulse.
- R10: `busy_o` is high from the cycle after an accepted start through the final transfer. A start pulse while busy does not change the transfers and adds none.
- R11: After reset, `xfer_valid_o`, `busy_o`, `done_o`, `wb_valid_o` and `err_o` are low.
- R12: A start presented in the completion cycle is accepted. Its first transfer appears in the next cycle.
- R13: The first transfer appears in the cycle after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request strobe |
| base_i | input | 32 | Base address |
| reg_mask_i | input | 16 | Register selection mask |
| up_i | input | 1 | 1 = ascending base adjustment, 0 = descending |
| pre_i | input | 1 | 1 = step before each access, 0 = step after |
| wb_i | input | 1 | Request the adjusted base at completion |
| xfer_valid_o | output | 1 | A transfer is presented this cycle |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_last_o | output | 1 | Marks the final transfer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| wb_valid_o | output | 1 | Adjusted base is valid |
| wb_base_o | output | 32 | Adjusted base address |
| err_o | output | 1 | Empty-mask refusal pulse |

## Verification
Completion of one sequence and acceptance of the next request can land in the same cycle. The bench provokes this by raising start exactly when the completion pulse and the written-back base of the previous request are visible. It then judges that both the completion values are correct and that the new sequence begins on the following cycle at its own address. The opposite case is also driven: a start raised while the final transfer is still shown. That start must be ignored, which the bench judges by seeing no extra transfer after the completion pulse.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned NREG   = 16;
  localparam int unsigned STEP   = 4;

  typedef enum logic [1:0] {
    AM_UP_AFTER   = 2'b10,
    AM_UP_BEFORE  = 2'b11,
    AM_DN_AFTER   = 2'b00,
    AM_DN_BEFORE  = 2'b01
  } addr_mode_e;
endpackage

// File: rtl/bxs_rst_sync.sv
module bxs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
  parameter int unsigned N = 16,
  localparam int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] part [N+1];

  assign part[0] = '0;
  for (genvar gi = 0; gi < N; gi++) begin : g_sum
    assign part[gi+1] = part[gi] + CNT_W'(vec[gi]);
  end

  assign count = part[N];
endmodule

// File: rtl/bxs_lowest.sv
module bxs_lowest #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             single
);
  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar gi = 0; gi < N; gi++) begin : g_pick
    assign onehot[gi]  = vec[gi] & ~below[gi];
    assign below[gi+1] = below[gi] | vec[gi];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

  // exactly one bit remaining
  assign single = below[N] & ((vec & ~onehot) == '0);
endmodule

// File: rtl/bxs_addr_plan.sv
module bxs_addr_plan
  import bxs_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NR    = NREG,
  parameter int unsigned STP   = STEP,
  localparam int unsigned CNT_W = $clog2(NR + 1),
  localparam int unsigned SH    = $clog2(STP)
) (
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] count,
  input  logic             up,
  input  logic             pre,
  output logic [AW-1:0]    first_addr,
  output logic [AW-1:0]    final_base
);
  logic [AW-1:0] span;
  logic [AW-1:0] low;
  addr_mode_e    mode;

  assign span = AW'(count) << SH;
  assign low  = base - span;
  assign mode = addr_mode_e'({up, pre});

  always_comb begin
    unique case (mode)
      AM_UP_AFTER:  first_addr = base;
      AM_UP_BEFORE: first_addr = base + AW'(STP);
      AM_DN_AFTER:  first_addr = low + AW'(STP);
      default:      first_addr = low;
    endcase
    final_base = up ? (base + span) : low;
  end
endmodule

// File: rtl/bxs_seq.sv
module bxs_seq
  import bxs_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned NR  = NREG,
  parameter int unsigned STP = STEP,
  localparam int unsigned CNT_W = $clog2(NR + 1),
  localparam int unsigned IDX_W = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [NR-1:0]    reg_mask_i,
  input  logic             up_i,
  input  logic             pre_i,
  input  logic             wb_i,
  output logic             xfer_valid_o,
  output logic [AW-1:0]    xfer_addr_o,
  output logic [IDX_W-1:0] xfer_reg_o,
  output logic             xfer_last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             wb_valid_o,
  output logic [AW-1:0]    wb_base_o,
  output logic             err_o
);
  logic rst_int_n;

  logic          busy_q,  busy_d;
  logic [NR-1:0] mask_q,  mask_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [AW-1:0] fin_q;
  logic          wbreq_q;
  logic          done_q,  done_d;
  logic          wbv_q,   wbv_d;
  logic          err_q,   err_d;

  logic             accept, accept_ok, accept_empty;
  logic             walk_en;
  logic [CNT_W-1:0] in_count;
  logic [AW-1:0]    plan_first, plan_final;
  logic [NR-1:0]    cur_onehot;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_single;

  bxs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bxs_popcount #(.N(NR)) u_cnt (
    .vec   (reg_mask_i),
    .count (in_count)
  );

  bxs_addr_plan #(.AW(AW), .NR(NR), .STP(STP)) u_plan (
    .base       (base_i),
    .count      (in_count),
    .up         (up_i),
    .pre        (pre_i),
    .first_addr (plan_first),
    .final_base (plan_final)
  );

  bxs_lowest #(.N(NR)) u_low (
    .vec    (mask_q),
    .onehot (cur_onehot),
    .idx    (cur_idx),
    .single (cur_single)
  );

  // next-state
  always_comb begin
    accept       = start_i & ~busy_q;
    accept_ok    = accept & (|reg_mask_i);
    accept_empty = accept & ~(|reg_mask_i);
    walk_en      = accept_ok | busy_q;

    busy_d = busy_q;
    mask_d = mask_q;
    addr_d = addr_q;
    if (accept_ok) begin
      busy_d = 1'b1;
      mask_d = reg_mask_i;
      addr_d = plan_first;
    end else if (busy_q) begin
      busy_d = ~cur_single;
      mask_d = mask_q & ~cur_onehot;
      addr_d = addr_q + AW'(STP);
    end

    done_d = busy_q & cur_single;
    wbv_d  = busy_q & cur_single & wbreq_q;
    err_d  = accept_empty;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q  <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      fin_q   <= '0;
      wbreq_q <= 1'b0;
      done_q  <= 1'b0;
      wbv_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      wbv_q  <= wbv_d;
      err_q  <= err_d;
      if (walk_en) begin
        mask_q <= mask_d;
        addr_q <= addr_d;
      end
      if (accept_ok) begin
        fin_q   <= plan_final;
        wbreq_q <= wb_i;
      end
    end
  end

  assign xfer_valid_o = busy_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_reg_o   = cur_idx;
  assign xfer_last_o  = busy_q & cur_single;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign wb_valid_o   = wbv_q;
  assign wb_base_o    = wbv_q ? fin_q : '0;
  assign err_o        = err_q;
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 4,
  parameter int unsigned STP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          xfer_valid_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic [IW-1:0] xfer_reg_o,
  input logic          xfer_last_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          wb_valid_o,
  input logic          err_o
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_last_o) |=> (xfer_valid_o && xfer_addr_o == $past(xfer_addr_o) + AW'(STP))); // R2
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_last_o) |=> (xfer_valid_o && xfer_reg_o > $past(xfer_reg_o))); // R1
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_last_o) |=> (done_o && !xfer_valid_o)); // R8
  AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(xfer_last_o)); // R8
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o); // R7
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!xfer_valid_o && !done_o)); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R9
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_last_o && start_i) |=> busy_o); // R10
endmodule

bind bxs_seq bxs_chk #(.AW(AW), .IW(IDX_W), .STP(STP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .start_i      (start_i),
  .xfer_valid_o (xfer_valid_o),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_reg_o   (xfer_reg_o),
  .xfer_last_o  (xfer_last_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .wb_valid_o   (wb_valid_o),
  .err_o        (err_o)
);

// File: tb/bxs_seq_tb.sv
module bxs_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] reg_mask_i;
  logic        up_i, pre_i, wb_i;
  logic        xfer_valid_o, xfer_last_o, busy_o, done_o, wb_valid_o, err_o;
  logic [31:0] xfer_addr_o, wb_base_o;
  logic [3:0]  xfer_reg_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  bxs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .reg_mask_i(reg_mask_i), .up_i(up_i), .pre_i(pre_i), .wb_i(wb_i),
    .xfer_valid_o(xfer_valid_o), .xfer_addr_o(xfer_addr_o),
    .xfer_reg_o(xfer_reg_o), .xfer_last_o(xfer_last_o), .busy_o(busy_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o),
    .err_o(err_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL R13 watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] b, input logic [15:0] m,
                        input bit up, input bit pre, input bit wb);
    base_i = b; reg_mask_i = m; up_i = up; pre_i = pre; wb_i = wb; start_i = 1'b1;
  endtask

  // called at the negedge after the launch negedge; ends at the completion negedge
  task automatic check_seq(input logic [31:0] b, input logic [15:0] m,
                           input bit up, input bit pre, input bit wb, input bit poke);
    int n = $countones(m);
    logic [31:0] span = 32'(n) * 32'd4;
    logic [31:0] first, fin;
    string mtag;
    int k = 0;
    start_i = 1'b0;
    if (up) begin
      first = pre ? b + 32'd4 : b;
      fin   = b + span;
      mtag  = pre ? "R4 first addr" : "R3 first addr";
    end else begin
      first = pre ? b - span : b - span + 32'd4;
      fin   = b - span;
      mtag  = pre ? "R6 first addr" : "R5 first addr";
    end
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        chk("R13 xfer valid", 32'(xfer_valid_o), 32'd1);
        chk("R1 reg index", 32'(xfer_reg_o), 32'(i));
        chk(k == 0 ? mtag : "R2 addr step", xfer_addr_o, first + 32'(k) * 32'd4);
        chk("R8 last flag", 32'(xfer_last_o), 32'(k == n - 1));
        chk("R10 busy", 32'(busy_o), 32'd1);
        if (poke && k == 0) begin
          start_i = 1'b1; reg_mask_i = 16'hFFFF; base_i = 32'hDEAD_0000;
        end
        k++;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    chk("R8 done pulse", 32'(done_o), 32'd1);
    chk("R8 no xfer at done", 32'(xfer_valid_o), 32'd0);
    chk("R10 busy low at done", 32'(busy_o), 32'd0);
    chk("R7 wb valid", 32'(wb_valid_o), 32'(wb));
    if (wb) chk("R7 wb base", wb_base_o, fin);
    if (poke) begin
      @(negedge clk);
      chk("R10 ignored start adds no xfer", 32'(xfer_valid_o), 32'd0);
      chk("R10 ignored start adds no done", 32'(done_o), 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R11 valid", 32'(xfer_valid_o), 32'd0);
    chk("R11 busy", 32'(busy_o), 32'd0);
    chk("R11 done", 32'(done_o), 32'd0);
    chk("R11 wb valid", 32'(wb_valid_o), 32'd0);
    chk("R11 err", 32'(err_o), 32'd0);
  endtask

  task automatic t_op(input logic [31:0] b, input logic [15:0] m,
                      input bit up, input bit pre, input bit wb, input bit poke);
    launch(b, m, up, pre, wb);
    @(negedge clk);
    check_seq(b, m, up, pre, wb, poke);
    @(negedge clk);
  endtask

  task automatic t_empty;
    launch(32'h0000_4000, 16'h0000, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 err pulse", 32'(err_o), 32'd1);
    chk("R9 no xfer", 32'(xfer_valid_o), 32'd0);
    chk("R9 not busy", 32'(busy_o), 32'd0);
    @(negedge clk);
    chk("R9 err one cycle", 32'(err_o), 32'd0);
    chk("R9 no done", 32'(done_o), 32'd0);
    chk("R9 no xfer later", 32'(xfer_valid_o), 32'd0);
  endtask

  task automatic t_chain;
    launch(32'h0000_2000, 16'h0C00, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check_seq(32'h0000_2000, 16'h0C00, 1'b1, 1'b1, 1'b1, 1'b0);
    launch(32'h0000_3000, 16'h0005, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R12 start in done cycle accepted", 32'(xfer_valid_o), 32'd1);
    check_seq(32'h0000_3000, 16'h0005, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; reg_mask_i = '0;
    up_i = 1'b0; pre_i = 1'b0; wb_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_op(32'h0000_1000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0);
    t_op(32'h0000_1000, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b0);
    t_op(32'h0000_1000, 16'h00F0, 1'b0, 1'b0, 1'b1, 1'b0);
    t_op(32'h0000_0020, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
    t_op(32'hFFFF_FFF8, 16'h0013, 1'b1, 1'b0, 1'b1, 1'b0);
    t_op(32'h0000_5000, 16'h2402, 1'b1, 1'b0, 1'b0, 1'b0);
    t_empty();
    t_op(32'h0000_6000, 16'h0030, 1'b1, 1'b0, 1'b1, 1'b1);
    t_op(32'h0000_7000, 16'h4000, 1'b0, 1'b1, 1'b1, 1'b1);
    t_chain();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule